// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a 32-bit register file and a 32-bit data memory bus. It handles the data path for byte, word and longword accesses. On a store it places the register value on the right byte lanes of the bus and sets the matching byte enables. On a load it takes the addressed bytes from the returned bus word and sign-extends them to a full 32-bit register value.

Every request is checked for alignment. A misaligned word or longword access is not split into smaller accesses. Instead the block raises an address error in the same cycle and blocks every memory strobe. A faulting load also returns an error completion and no data.

Byte order is chosen by a mode pin. The pin is sampled only while the synchronised power-on reset is active, and the chosen order then stays fixed until the next reset. One load may be outstanding at a time. The memory side answers it with a read-valid pulse, and the result appears on registered outputs one cycle later.

Top module: `ldst_align_unit`

## Requirements
- R1: The byte order is sampled from `endian_pin` while reset is in force. A low pin selects big-endian and a high pin selects little-endian. Byte lane k is bus bits 8k+7:8k. In big-endian mode, address offset o maps to lane 3-o. In little-endian mode, offset o maps to lane o.
- R2: Once reset is released, changes on `endian_pin` have no effect on lane mapping until the next reset.
- R3: A byte store (`req_size` 00) at any offset asserts exactly one `mem_be` bit, the lane of R1. It drives register bits 7:0 onto all four lanes of `mem_wdata`.
- R4: A word store (`req_size` 01) at an even address drives register bits 15:0 onto both halves of `mem_wdata`. It sets `mem_be` to 0011 in two cases: little-endian at offset 0, or big-endian at offset 2. In the other two cases it sets `mem_be` to 1100.
- R5: A longword store (`req_size` 10) at offset 0 sets `mem_be` to 1111 and passes the register value unchanged. For every accepted access, `mem_addr` is the request address with bits 1:0 cleared, and `mem_we` is high for a store.
- R6: An address error is raised in the same cycle as the request, and `addr_err` goes high, when any of these holds:
  - a word request has address bit 0 set;
  - a longword request has address bits 1:0 not equal to 00;
  - the size code is 11.

  While `addr_err` is high, `mem_be` is 0000 and `mem_we` and `mem_re` are low.
- R7: A byte access never raises `addr_err`, whatever its offset.
- R8: In the cycle after `mem_rvalid` answers a pending byte load, `ld_valid` is high and `ld_err` is low. `ld_data` holds the addressed byte, sign-extended from its bit 7.
- R9: A word load returns the two addressed bytes as a 16-bit value in the selected byte order, sign-extended from bit 15. It uses the same timing as R8.
- R10: A longword load returns `mem_rdata` unchanged, with the same timing as R8.
- R11: A misaligned load issues no `mem_re`. In the next cycle it gives `ld_valid` high, `ld_err` high and `ld_data` zero.
- R12: A `mem_rvalid` pulse with no load pending produces no `ld_valid`. After reset, `ld_valid`, `ld_err`, `mem_we` and `mem_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| endian_pin | input | 1 | Byte-order select, sampled during reset (0 big, 1 little) |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 32 | Register value to store |
| mem_addr | output | AW | Longword-aligned bus address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane enables, bit k for bits 8k+7:8k |
| mem_wdata | output | 32 | Store data placed on lanes |
| mem_rvalid | input | 1 | Read data valid for the pending load |
| mem_rdata | input | 32 | Read data word |
| addr_err | output | 1 | Address error for the current request |
| ld_valid | output | 1 | Load completion, one cycle after read data or fault |
| ld_err | output | 1 | Completion is an address error, no write-back |
| ld_data | output | 32 | Sign-extended load result |

## Verification
A wrong captured byte order shows at once on the next byte or word access. The enables land on the mirrored lane, and a load returns the mirrored byte in the very cycle its completion appears. A corrupted pending-load context shows when that load completes: the result is drawn from the wrong lane or extended from the wrong width, one cycle after `mem_rvalid`. A stuck pending flag shows either as a missing completion or as a spurious `ld_valid` one cycle after an unrelated read-valid pulse. A faulty alignment check shows in the request cycle itself, as enables or strobes that leak out beside `addr_err`.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DW    = 32;
  localparam int LW    = 8;
  localparam int LANES = DW / LW;
  localparam int OFFW  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_FULL = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    acc_size_e       size;
    logic [OFFW-1:0] off;
  } ld_ctx_t;
endpackage

// File: rtl/lsa_reset_sync.sv
module lsa_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/lsa_endian_latch.sv
module lsa_endian_latch (
  input  logic clk,
  input  logic srst_n,
  input  logic mode_pin,
  output logic little
);
  logic little_q;
  logic cap_en;

  // Capture only while reset holds; frozen afterwards.
  assign cap_en = ~srst_n;

  always_ff @(posedge clk) begin
    if (cap_en) little_q <= mode_pin;
  end

  assign little = little_q;
endmodule

// File: rtl/lsa_align_check.sv
module lsa_align_check
  import lsa_pkg::*;
(
  input  acc_size_e       size,
  input  logic [OFFW-1:0] off,
  output logic            misalign
);
  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = off[0];
      SZ_FULL: misalign = |off;
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
(
  input  acc_size_e       size,
  input  logic [OFFW-1:0] off,
  input  logic            little,
  input  logic [DW-1:0]   src,
  output logic [LANES-1:0] be,
  output logic [DW-1:0]   wdata
);
  logic [OFFW-1:0] byte_lane;
  logic            half_idx;

  assign byte_lane = little ? off : ~off;
  assign half_idx  = little ? off[OFFW-1] : ~off[OFFW-1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFFW-1:0] KIDX = OFFW'(k);
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[k]            = (byte_lane == KIDX);
          wdata[k*LW +: LW] = src[LW-1:0];
        end
        SZ_HALF: begin
          be[k]            = (KIDX[OFFW-1] == half_idx);
          wdata[k*LW +: LW] = src[(k % 2)*LW +: LW];
        end
        SZ_FULL: begin
          be[k]            = 1'b1;
          wdata[k*LW +: LW] = src[k*LW +: LW];
        end
        default: begin
          be[k]            = 1'b0;
          wdata[k*LW +: LW] = src[k*LW +: LW];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  acc_size_e       size,
  input  logic [OFFW-1:0] off,
  input  logic            little,
  input  logic [DW-1:0]   rdata,
  output logic [DW-1:0]   result
);
  logic [OFFW-1:0] byte_lane;
  logic            half_idx;
  logic [LW-1:0]   byte_v;
  logic [2*LW-1:0] half_v;

  assign byte_lane = little ? off : ~off;
  assign half_idx  = little ? off[OFFW-1] : ~off[OFFW-1];
  assign byte_v    = rdata[{byte_lane, 3'b000} +: LW];
  assign half_v    = rdata[{half_idx, 4'b0000} +: 2*LW];

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(DW-LW){byte_v[LW-1]}}, byte_v};
      SZ_HALF: result = {{(DW-2*LW){half_v[2*LW-1]}}, half_v};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import lsa_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          endian_pin,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          addr_err,
  output logic          ld_valid,
  output logic          ld_err,
  output logic [31:0]   ld_data
);
  logic            srst_n;
  logic            little;
  logic            misalign;
  acc_size_e       size_in;
  logic [OFFW-1:0] off_in;
  logic [LANES-1:0] be_raw;
  logic [DW-1:0]   wd_raw;
  logic [DW-1:0]   ld_ext;
  logic            accept;
  logic            fault_ld;
  logic            take;

  logic            pend_q,  pend_d;
  ld_ctx_t         ctx_q,   ctx_d;
  logic            ctx_en;
  logic            lv_q,    lv_d;
  logic            le_q,    le_d;
  logic [DW-1:0]   ldd_q,   ldd_d;
  logic            ldd_en;

  assign size_in = acc_size_e'(req_size);
  assign off_in  = req_addr[OFFW-1:0];

  lsa_reset_sync #(.STAGES(SYNC_DEPTH)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lsa_endian_latch u_endian (
    .clk      (clk),
    .srst_n   (srst_n),
    .mode_pin (endian_pin),
    .little   (little)
  );

  lsa_align_check u_align (
    .size     (size_in),
    .off      (off_in),
    .misalign (misalign)
  );

  lsa_store_steer u_steer (
    .size   (size_in),
    .off    (off_in),
    .little (little),
    .src    (req_wdata),
    .be     (be_raw),
    .wdata  (wd_raw)
  );

  lsa_load_extract u_extract (
    .size   (ctx_q.size),
    .off    (ctx_q.off),
    .little (little),
    .rdata  (mem_rdata),
    .result (ld_ext)
  );

  // Request side
  assign accept    = req_valid & ~misalign;
  assign addr_err  = req_valid & misalign;
  assign mem_addr  = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
  assign mem_we    = accept & req_write;
  assign mem_re    = accept & ~req_write;
  assign mem_be    = accept ? be_raw : '0;
  assign mem_wdata = wd_raw;

  assign fault_ld  = req_valid & ~req_write & misalign;
  assign take      = pend_q & mem_rvalid;

  // Pending-load context: next state
  always_comb begin
    pend_d = pend_q;
    ctx_en = 1'b0;
    ctx_d  = ctx_q;
    if (mem_re) begin
      pend_d = 1'b1;
      ctx_en = 1'b1;
      ctx_d  = '{size: size_in, off: off_in};
    end else if (take) begin
      pend_d = 1'b0;
    end
  end

  // Completion: next state
  always_comb begin
    lv_d   = 1'b0;
    le_d   = 1'b0;
    ldd_en = 1'b0;
    ldd_d  = ldd_q;
    if (take) begin
      lv_d   = 1'b1;
      ldd_en = 1'b1;
      ldd_d  = ld_ext;
    end else if (fault_ld) begin
      lv_d   = 1'b1;
      le_d   = 1'b1;
      ldd_en = 1'b1;
      ldd_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      lv_q   <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lv_q   <= lv_d;
      le_q   <= le_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ctx_en) ctx_q <= ctx_d;
    if (ldd_en) ldd_q <= ldd_d;
  end

  assign ld_valid = lv_q;
  assign ld_err   = le_q;
  assign ld_data  = ldd_q;
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker (
  input logic       clk,
  input logic       srst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic [1:0] req_size,
  input logic [3:0] mem_be,
  input logic       mem_we,
  input logic       mem_re,
  input logic       addr_err,
  input logic       mem_rvalid,
  input logic       ld_valid,
  input logic       ld_err,
  input logic       pend,
  input logic       little
);
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> $stable(little)); // R2

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_size == 2'b00) |-> $countones(mem_be) == 1); // R3

  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_size == 2'b01 && !addr_err) |-> $countones(mem_be) == 2); // R4

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!srst_n)
    addr_err |-> (mem_be == 4'b0000 && !mem_we && !mem_re)); // R6

  AST_BYTE_NO_ERR: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_size == 2'b00) |-> !addr_err); // R7

  AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!srst_n)
    (pend && mem_rvalid) |=> (ld_valid && !ld_err)); // R8

  AST_FAULT_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && !req_write && addr_err && !(pend && mem_rvalid)) |=> (ld_valid && ld_err)); // R11

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!srst_n)
    (!(pend && mem_rvalid) && !(req_valid && !req_write && addr_err)) |=> !ld_valid); // R12
endmodule

bind ldst_align_unit lsa_checker u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .mem_be     (mem_be),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .addr_err   (addr_err),
  .mem_rvalid (mem_rvalid),
  .ld_valid   (ld_valid),
  .ld_err     (ld_err),
  .pend       (pend_q),
  .little     (little)
);

// File: tb/ldst_align_unit_test.sv
module ldst_align_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        endian_pin;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] mem_addr;
  logic        mem_re;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        addr_err;
  logic        ld_valid;
  logic        ld_err;
  logic [31:0] ld_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ldst_align_unit uut (
    .clk(clk), .rst_n(rst_n), .endian_pin(endian_pin),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .addr_err(addr_err), .ld_valid(ld_valid), .ld_err(ld_err),
    .ld_data(ld_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] e_be(input bit le, input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'b00:   return le ? (4'b0001 << off) : (4'b1000 >> off);
      2'b01:   return (le == (off[1] == 1'b0)) ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] e_wd(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [7:0] mbyte(input bit le, input logic [31:0] r, input int i);
    return le ? r[8*i +: 8] : r[8*(3-i) +: 8];
  endfunction

  function automatic logic [31:0] e_ld(input bit le, input logic [1:0] sz, input logic [1:0] off,
                                       input logic [31:0] r);
    logic [7:0]  b;
    logic [15:0] h;
    case (sz)
      2'b00: begin
        b = mbyte(le, r, int'(off));
        return {{24{b[7]}}, b};
      end
      2'b01: begin
        h = le ? {mbyte(le, r, int'(off) + 1), mbyte(le, r, int'(off))}
               : {mbyte(le, r, int'(off)), mbyte(le, r, int'(off) + 1)};
        return {{16{h[15]}}, h};
      end
      default: return r;
    endcase
  endfunction

  task automatic idle();
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_size   = 2'b00;
    req_addr   = '0;
    req_wdata  = '0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  endtask

  task automatic do_reset(input bit pin);
    @(negedge clk);
    idle();
    rst_n      = 1'b0;
    endian_pin = pin;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R12 reset ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R12 reset ld_err",   {31'd0, ld_err},   32'd0);
    chk("R12 reset mem_we",   {31'd0, mem_we},   32'd0);
    chk("R12 reset mem_re",   {31'd0, mem_re},   32'd0);
  endtask

  task automatic t_store(input bit le, input logic [1:0] sz, input logic [31:0] addr,
                         input logic [31:0] d);
    string tag;
    tag = (sz == 2'b00) ? "R3" : (sz == 2'b01) ? "R4" : "R5";
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = addr; req_wdata = d;
    #1;
    chk({tag, " be"},    {28'd0, mem_be}, {28'd0, e_be(le, sz, addr[1:0])});
    chk({tag, " wdata"}, mem_wdata, e_wd(sz, d));
    chk({tag, " we"},    {31'd0, mem_we}, 32'd1);
    chk("R5 mem_addr",   mem_addr, {addr[31:2], 2'b00});
    if (sz == 2'b00) chk("R7 byte no err", {31'd0, addr_err}, 32'd0);
    @(negedge clk);
    idle();
  endtask

  task automatic t_load(input bit le, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] r);
    string tag;
    tag = (sz == 2'b00) ? "R8" : (sz == 2'b01) ? "R9" : "R10";
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = addr;
    #1;
    chk({tag, " re"}, {31'd0, mem_re}, 32'd1);
    @(negedge clk);
    idle();
    mem_rvalid = 1'b1; mem_rdata = r;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    #1;
    chk({tag, " valid"}, {31'd0, ld_valid}, 32'd1);
    chk({tag, " err"},   {31'd0, ld_err},   32'd0);
    chk({tag, " data"},  ld_data, e_ld(le, sz, addr[1:0], r));
  endtask

  task automatic t_misalign(input bit wr, input logic [1:0] sz, input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = 32'hA5A5_5A5A;
    #1;
    chk("R6 addr_err", {31'd0, addr_err}, 32'd1);
    chk("R6 be",       {28'd0, mem_be},   32'd0);
    chk("R6 we",       {31'd0, mem_we},   32'd0);
    chk("R6 re",       {31'd0, mem_re},   32'd0);
    @(negedge clk);
    idle();
    #1;
    if (!wr) begin
      chk("R11 valid", {31'd0, ld_valid}, 32'd1);
      chk("R11 err",   {31'd0, ld_err},   32'd1);
      chk("R11 data",  ld_data,           32'd0);
    end else begin
      chk("R12 no completion after store", {31'd0, ld_valid}, 32'd0);
    end
  endtask

  task automatic t_mode(input bit le);
    t_store(le, 2'b00, 32'h100, 32'h0000_0077);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'b00; req_addr = 32'h100;
    #1;
    chk("R1 lane of offset 0", {28'd0, mem_be}, le ? 32'h1 : 32'h8);
    @(negedge clk);
    idle();
    endian_pin = ~endian_pin;
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'b00; req_addr = 32'h101;
    #1;
    chk("R2 mode frozen", {28'd0, mem_be}, le ? 32'h2 : 32'h4);
    @(negedge clk);
    idle();
  endtask

  task automatic t_spurious();
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h1234_5678;
    @(negedge clk);
    mem_rvalid = 1'b0;
    #1;
    chk("R12 spurious rvalid", {31'd0, ld_valid}, 32'd0);
  endtask

  task automatic t_all(input bit le);
    t_mode(le);
    for (int o = 0; o < 4; o++) t_store(le, 2'b00, 32'h2000 + o, 32'h1357_9BC0 + o);
    for (int o = 0; o < 4; o += 2) t_store(le, 2'b01, 32'h2000 + o, 32'hFFFF_8421 + o);
    t_store(le, 2'b10, 32'h2004, 32'hCAFE_F00D);
    for (int o = 0; o < 4; o++) t_load(le, 2'b00, 32'h3000 + o, 32'h8F7E_01C3);
    for (int o = 0; o < 4; o++) t_load(le, 2'b00, 32'h3000 + o, 32'h7080_FF12);
    for (int o = 0; o < 4; o += 2) t_load(le, 2'b01, 32'h3000 + o, 32'h8123_7F45);
    for (int o = 0; o < 4; o += 2) t_load(le, 2'b01, 32'h3000 + o, 32'h0080_80FF);
    t_load(le, 2'b10, 32'h3008, 32'h9ABC_DEF0);
    t_misalign(1'b1, 2'b01, 32'h4001);
    t_misalign(1'b0, 2'b01, 32'h4003);
    t_misalign(1'b1, 2'b10, 32'h4002);
    t_misalign(1'b0, 2'b10, 32'h4001);
    t_misalign(1'b0, 2'b10, 32'h4003);
    t_misalign(1'b0, 2'b11, 32'h4000);
    t_spurious();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    endian_pin = 1'b0;
    idle();
    do_reset(1'b0);
    t_all(1'b0);
    do_reset(1'b1);
    t_all(1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule